// File: doc/BRIEF.md
# Sleep State Sequencer

This block moves a system between the fully-on state and four sleep depths: a shallow processor-only state (S1), suspend-to-memory (S3), suspend-to-disk (S4) and soft-off (S5). Software picks a depth by presenting a 3-bit type code together with a sleep-enable write strobe. A power button held for a parameterised number of slow always-on ticks forces soft-off, whatever state the controller is in. Each state drives its own set of active-low controls: a processor clock-stop request, an optional processor sleep line, and three rail-gating lines that remove power in steps.

While sleeping, the block latches wake events from a vector of wake sources and from a power-button press. A latched event returns the controller to fully-on and sets a sticky wake-status flag, which software clears by writing 1. A battery-low input blocks all wakes but lets events keep latching, so the wake happens as soon as battery-low drops. Thermal throttling passes through only in the fully-on state, and it is cut in the same cycle as a valid sleep request.

The states are ST_ON, ST_S1, ST_S3, ST_S4 and ST_S5. The transitions are: enter (ST_ON to the requested sleep state on a valid request), wake (any sleep state to ST_ON when a wake is pending and battery-low is clear), and override (any state to ST_S5 when the button hold completes). Override takes priority over wake, and wake takes priority over enter.

Top module: `slp_seq_top`

## Requirements
- R1: With `sw_wr` and `sw_slp_en` high in ST_ON, the type codes 001, 101, 110 and 111 on `sw_typ` select S1, S3, S4 and S5. The new state takes effect after the next rising clock edge.
- R2: In S1, `stpclk_n` is low. `cpuslp_n` is low only when `cpuslp_cfg` is 1. All three rail lines stay high.
- R3: In S3, only `rail_s3_n` is low, and `stpclk_n` is high.
- R4: In S4, `rail_s3_n` and `rail_s4_n` are low and `rail_s5_n` is high.
- R5: In S5, `rail_s3_n`, `rail_s4_n` and `rail_s5_n` are all low.
- R6: Holding `pwr_btn_n` low for HOLD_TICKS `tick_en` cycles moves the controller to S5 at the clock edge of the last tick. This happens from any state and does not depend on `batt_low`. Releasing the button resets the count.
- R7: `throttle` follows `therm_req` only in ST_ON. It is forced low in any cycle that carries a valid sleep request.
- R8: While sleeping, a high bit of `wake_evt` or a falling edge of `pwr_btn_n` becomes pending at the next edge, and the controller reaches ST_ON one edge later. At that same edge `wak_sts` sets. `sw_wak_clr` clears `wak_sts` unless a wake sets it in the same cycle.
- R9: While `batt_low` is high, no wake happens. Events that arrive during that time stay latched, and the wake completes at the first edge after `batt_low` falls.
- R10: Type codes other than the four in R1 are ignored, and so are writes made while sleeping. No write reaches any state outside the five listed.
- R11: After reset, the controller is in ST_ON, every active-low output is high, and `wak_sts` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Slow always-on tick enable for the button timer |
| sw_wr | input | 1 | Software write strobe |
| sw_typ | input | 3 | Requested sleep type code |
| sw_slp_en | input | 1 | Sleep-enable bit carried by the write |
| sw_wak_clr | input | 1 | Write-1 clear of the wake status |
| cpuslp_cfg | input | 1 | Enables the processor sleep line in S1 |
| pwr_btn_n | input | 1 | Power button, low when pressed |
| wake_evt | input | WAKE_N | Wake event sources, active high |
| batt_low | input | 1 | Battery-low, blocks waking |
| therm_req | input | 1 | Thermal throttle request |
| stpclk_n | output | 1 | Processor clock-stop request |
| cpuslp_n | output | 1 | Processor sleep line |
| rail_s3_n | output | 1 | Non-critical rail gate |
| rail_s4_n | output | 1 | Memory rail gate |
| rail_s5_n | output | 1 | Remaining rail gate |
| throttle | output | 1 | Thermal throttling active |
| wak_sts | output | 1 | Sticky wake status |

## Verification
Every output is decoded from the state register, so a wrong state shows on the clock-stop or rail lines in the same cycle that it is entered. A wake latch that drops or invents an event shows as an exit that comes late, never comes, or comes without cause, one edge after the pending flag should have changed. A button counter that is off by one moves the S5 transition by one tick period. The bench's reference model compares every output on every clock, so any of these errors is caught at the first cycle in which it shows.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [2:0] {
        ST_ON = 3'd0,
        ST_S1 = 3'd1,
        ST_S3 = 3'd3,
        ST_S4 = 3'd4,
        ST_S5 = 3'd5
    } slp_state_t;

    localparam logic [2:0] TYP_S1 = 3'b001;
    localparam logic [2:0] TYP_S3 = 3'b101;
    localparam logic [2:0] TYP_S4 = 3'b110;
    localparam logic [2:0] TYP_S5 = 3'b111;

    function automatic logic typ_ok(input logic [2:0] typ);
        return (typ == TYP_S1) || (typ == TYP_S3) ||
               (typ == TYP_S4) || (typ == TYP_S5);
    endfunction

    function automatic slp_state_t typ_target(input logic [2:0] typ);
        slp_state_t st;
        unique case (typ)
            TYP_S1:  st = ST_S1;
            TYP_S3:  st = ST_S3;
            TYP_S4:  st = ST_S4;
            TYP_S5:  st = ST_S5;
            default: st = ST_ON;
        endcase
        return st;
    endfunction

endpackage

// File: rtl/slp_btn_timer.sv
module slp_btn_timer #(
    parameter int HOLD_TICKS = 131072
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic pwr_btn_n,
    output logic press,
    output logic ovr
);
    localparam int CW = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);
    localparam logic [CW-1:0] FULL = CW'(HOLD_TICKS);

    logic [CW-1:0] cnt;
    logic          btn_prev;

    assign press = btn_prev && !pwr_btn_n;
    assign ovr   = !pwr_btn_n && tick_en && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            btn_prev <= 1'b1;
        end else begin
            btn_prev <= pwr_btn_n;
            if (pwr_btn_n)
                cnt <= '0;
            else if (tick_en && cnt != FULL)
                cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL); // R6

endmodule

// File: rtl/slp_wake_latch.sv
module slp_wake_latch #(
    parameter int WAKE_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAKE_N-1:0] wake_evt,
    input  logic              press,
    input  logic              asleep,
    input  logic              take,
    input  logic              ovr,
    input  logic              batt_low,
    output logic              pend
);
    logic any_evt;
    logic clr;

    assign any_evt = (|wake_evt) || press;
    assign clr     = !asleep || take || ovr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (clr)
            pend <= 1'b0;
        else if (any_evt)
            pend <= 1'b1;
    end

    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && asleep && batt_low && !ovr) |=> pend); // R9

endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import slp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_req,
    input  logic [2:0] sw_typ,
    input  logic       sw_wak_clr,
    input  logic       cpuslp_cfg,
    input  logic       ovr,
    input  logic       pend,
    input  logic       batt_low,
    input  logic       therm_req,
    output logic       asleep,
    output logic       take,
    output logic       stpclk_n,
    output logic       cpuslp_n,
    output logic       rail_s3_n,
    output logic       rail_s4_n,
    output logic       rail_s5_n,
    output logic       throttle,
    output logic       wak_sts
);
    slp_state_t state, nxt;
    logic       req_ok;

    assign req_ok = sw_req && typ_ok(sw_typ);
    assign asleep = (state != ST_ON);

    always_comb begin
        nxt  = state;
        take = 1'b0;
        if (ovr) begin
            nxt = ST_S5;
        end else begin
            unique case (state)
                ST_ON: if (req_ok) nxt = typ_target(sw_typ);
                ST_S1, ST_S3, ST_S4, ST_S5: begin
                    if (pend && !batt_low) begin
                        nxt  = ST_ON;
                        take = 1'b1;
                    end
                end
                default: nxt = ST_ON;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_ON;
            wak_sts <= 1'b0;
        end else begin
            state <= nxt;
            if (take)
                wak_sts <= 1'b1;
            else if (sw_wak_clr)
                wak_sts <= 1'b0;
        end
    end

    always_comb begin
        stpclk_n  = 1'b1;
        cpuslp_n  = 1'b1;
        rail_s3_n = 1'b1;
        rail_s4_n = 1'b1;
        rail_s5_n = 1'b1;
        throttle  = 1'b0;
        unique case (state)
            ST_ON: throttle = therm_req && !req_ok;
            ST_S1: begin
                stpclk_n = 1'b0;
                cpuslp_n = !cpuslp_cfg;
            end
            ST_S3: rail_s3_n = 1'b0;
            ST_S4: begin
                rail_s3_n = 1'b0;
                rail_s4_n = 1'b0;
            end
            ST_S5: begin
                rail_s3_n = 1'b0;
                rail_s4_n = 1'b0;
                rail_s5_n = 1'b0;
            end
            default: ;
        endcase
    end

    AST_OVR_TO_S5: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> (state == ST_S5)); // R6
    AST_BATLOW_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && batt_low && !ovr) |=> (state == $past(state))); // R9
    AST_WAK_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |=> (asleep || wak_sts)); // R8
    AST_BAD_TYPE_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep && sw_req && !typ_ok(sw_typ) && !ovr) |=> !asleep); // R10
    AST_NO_THR_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> !throttle); // R7

endmodule

// File: rtl/slp_seq_top.sv
module slp_seq_top #(
    parameter int HOLD_TICKS = 131072,
    parameter int WAKE_N     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              sw_wr,
    input  logic [2:0]        sw_typ,
    input  logic              sw_slp_en,
    input  logic              sw_wak_clr,
    input  logic              cpuslp_cfg,
    input  logic              pwr_btn_n,
    input  logic [WAKE_N-1:0] wake_evt,
    input  logic              batt_low,
    input  logic              therm_req,
    output logic              stpclk_n,
    output logic              cpuslp_n,
    output logic              rail_s3_n,
    output logic              rail_s4_n,
    output logic              rail_s5_n,
    output logic              throttle,
    output logic              wak_sts
);
    logic press, ovr, pend, asleep, take;

    slp_btn_timer #(.HOLD_TICKS(HOLD_TICKS)) u_btn (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .pwr_btn_n(pwr_btn_n), .press(press), .ovr(ovr)
    );

    slp_wake_latch #(.WAKE_N(WAKE_N)) u_wake (
        .clk(clk), .rst_n(rst_n), .wake_evt(wake_evt), .press(press),
        .asleep(asleep), .take(take), .ovr(ovr), .batt_low(batt_low),
        .pend(pend)
    );

    slp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_wr && sw_slp_en),
        .sw_typ(sw_typ), .sw_wak_clr(sw_wak_clr), .cpuslp_cfg(cpuslp_cfg),
        .ovr(ovr), .pend(pend), .batt_low(batt_low), .therm_req(therm_req),
        .asleep(asleep), .take(take), .stpclk_n(stpclk_n),
        .cpuslp_n(cpuslp_n), .rail_s3_n(rail_s3_n), .rail_s4_n(rail_s4_n),
        .rail_s5_n(rail_s5_n), .throttle(throttle), .wak_sts(wak_sts)
    );

endmodule

// File: tb/slp_seq_top_test.sv
module slp_seq_top_test;
    localparam int HOLD = 6;
    localparam int WN   = 2;

    logic clk = 0, rst_n = 0, tick_en = 0, tick_run = 0;
    logic sw_wr = 0, sw_slp_en = 0, sw_wak_clr = 0, cpuslp_cfg = 0;
    logic [2:0] sw_typ = 0;
    logic pwr_btn_n = 1, batt_low = 0, therm_req = 0;
    logic [WN-1:0] wake_evt = 0;
    logic stpclk_n, cpuslp_n, rail_s3_n, rail_s4_n, rail_s5_n, throttle, wak_sts;

    int total = 0, bad = 0;
    bit finished = 0;

    slp_seq_top #(.HOLD_TICKS(HOLD), .WAKE_N(WN)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sw_wr(sw_wr),
        .sw_typ(sw_typ), .sw_slp_en(sw_slp_en), .sw_wak_clr(sw_wak_clr),
        .cpuslp_cfg(cpuslp_cfg), .pwr_btn_n(pwr_btn_n), .wake_evt(wake_evt),
        .batt_low(batt_low), .therm_req(therm_req), .stpclk_n(stpclk_n),
        .cpuslp_n(cpuslp_n), .rail_s3_n(rail_s3_n), .rail_s4_n(rail_s4_n),
        .rail_s5_n(rail_s5_n), .throttle(throttle), .wak_sts(wak_sts)
    );

    always #10 clk = ~clk;

    // behavioural reference: ms is the sleep depth (0 = on)
    int ms = 0, cnt = 0;
    bit pend = 0, wak = 0, bprev = 1;

    function automatic int map_typ(input logic [2:0] t);
        case (t)
            3'b001: return 1;
            3'b101: return 3;
            3'b110: return 4;
            3'b111: return 5;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; cnt = 0; pend = 0; wak = 0; bprev = 1;
        end else begin
            bit press, ovr, wk, evt;
            int ns;
            press = bprev && !pwr_btn_n;
            ovr   = !pwr_btn_n && tick_en && (cnt == HOLD - 1);
            evt   = (wake_evt != 0) || press;
            ns = ms; wk = 0;
            if (ovr) ns = 5;
            else if (ms != 0 && pend && !batt_low) begin ns = 0; wk = 1; end
            else if (ms == 0 && sw_wr && sw_slp_en && map_typ(sw_typ) != 0)
                ns = map_typ(sw_typ);
            if (ms == 0 || ovr || wk) pend = 0;
            else if (evt) pend = 1;
            if (wk) wak = 1; else if (sw_wak_clr) wak = 0;
            if (pwr_btn_n) cnt = 0;
            else if (tick_en && cnt < HOLD) cnt = cnt + 1;
            bprev = pwr_btn_n;
            ms = ns;
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // every clock: compare all outputs with the model
    always @(negedge clk) if (rst_n && !finished) begin
        bit req_ok;
        req_ok = sw_wr && sw_slp_en && map_typ(sw_typ) != 0;
        chk("R2", "stpclk_n", stpclk_n, !(ms == 1));
        chk("R2", "cpuslp_n", cpuslp_n, !(ms == 1 && cpuslp_cfg));
        chk("R3", "rail_s3_n", rail_s3_n, !(ms >= 3));
        chk("R4", "rail_s4_n", rail_s4_n, !(ms >= 4));
        chk("R5", "rail_s5_n", rail_s5_n, !(ms == 5));
        chk("R7", "throttle", throttle, therm_req && ms == 0 && !req_ok);
        chk("R8", "wak_sts", wak_sts, wak);
    end

    always @(posedge clk) begin
        #2 tick_en = tick_run ? ~tick_en : 1'b0;
    end

    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #3; end
    endtask

    task automatic sw_write(input logic [2:0] t, input logic en);
        sw_wr = 1; sw_typ = t; sw_slp_en = en;
        cyc(1);
        sw_wr = 0; sw_slp_en = 0; sw_typ = 0;
    endtask

    task automatic pulse_wake(input int b);
        wake_evt[b] = 1; cyc(1); wake_evt = 0;
    endtask

    task automatic summary;
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog expired, actual=hung expected=done");
        summary();
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R11: reset state
        chk("R11", "stpclk_n after reset", stpclk_n, 1'b1);
        chk("R11", "rail_s5_n after reset", rail_s5_n, 1'b1);
        chk("R11", "wak_sts after reset", wak_sts, 1'b0);

        // R1 R2: S1 with processor sleep enabled, wake by event
        cpuslp_cfg = 1;
        sw_write(3'b001, 1);
        chk("R1", "S1 stpclk_n", stpclk_n, 1'b0);
        chk("R2", "S1 cpuslp_n", cpuslp_n, 1'b0);
        cyc(4);
        pulse_wake(0);
        cyc(1);
        chk("R8", "ON after wake", stpclk_n, 1'b1);
        chk("R8", "wak_sts set", wak_sts, 1'b1);
        sw_wak_clr = 1; cyc(1); sw_wak_clr = 0;
        chk("R8", "wak_sts cleared", wak_sts, 1'b0);

        // R2: S1 without processor sleep
        cpuslp_cfg = 0;
        sw_write(3'b001, 1);
        chk("R2", "cpuslp_n disabled", cpuslp_n, 1'b1);
        cyc(3); pulse_wake(1); cyc(3);

        // R3: S3, wake by button press
        sw_write(3'b101, 1);
        chk("R3", "S3 rail_s3_n", rail_s3_n, 1'b0);
        chk("R3", "S3 rail_s4_n", rail_s4_n, 1'b1);
        // R10: write while sleeping is ignored
        sw_write(3'b111, 1);
        chk("R10", "write in S3 ignored", rail_s5_n, 1'b1);
        pwr_btn_n = 0; cyc(2); pwr_btn_n = 1;
        chk("R8", "button wake", rail_s3_n, 1'b1);
        cyc(2);

        // R4, R5
        sw_write(3'b110, 1);
        chk("R4", "S4 rail_s4_n", rail_s4_n, 1'b0);
        cyc(3); pulse_wake(0); cyc(2);
        sw_write(3'b111, 1);
        chk("R5", "S5 rail_s5_n", rail_s5_n, 1'b0);
        // wake and clear in same cycle: set wins
        pulse_wake(1); sw_wak_clr = 1; cyc(1); sw_wak_clr = 0;
        chk("R8", "set beats clear", wak_sts, 1'b1);
        cyc(2);

        // R10: invalid types and enable-low writes
        sw_write(3'b000, 1); sw_write(3'b010, 1); sw_write(3'b100, 1);
        sw_write(3'b011, 1); sw_write(3'b101, 0);
        chk("R10", "invalid codes stay on", rail_s3_n, 1'b1);
        chk("R10", "invalid codes stay on clk", stpclk_n, 1'b1);

        // R7: throttling cut by sleep request and during sleep
        therm_req = 1; cyc(2);
        chk("R7", "throttle in ON", throttle, 1'b1);
        sw_wr = 1; sw_slp_en = 1; sw_typ = 3'b101;
        #5 chk("R7", "throttle cut by request", throttle, 1'b0);
        cyc(1); sw_wr = 0; sw_slp_en = 0;
        chk("R7", "throttle off asleep", throttle, 1'b0);

        // R9: battery low blocks wake, event latched
        batt_low = 1;
        pulse_wake(0);
        pwr_btn_n = 0; cyc(1); pwr_btn_n = 1;
        cyc(8);
        chk("R9", "still asleep", rail_s3_n, 1'b0);
        batt_low = 0; cyc(1);
        chk("R9", "wakes after release", rail_s3_n, 1'b1);
        therm_req = 0; cyc(2);

        // R6: partial holds reset, full hold overrides
        tick_run = 1;
        pwr_btn_n = 0; cyc(8); pwr_btn_n = 1; cyc(2);
        pwr_btn_n = 0; cyc(8); pwr_btn_n = 1; cyc(2);
        chk("R6", "short holds no override", rail_s5_n, 1'b1);
        pwr_btn_n = 0; cyc(2 * HOLD + 4);
        chk("R6", "long hold reaches S5", rail_s5_n, 1'b0);
        pwr_btn_n = 1; cyc(4);
        // override from S3 even with battery low
        sw_write(3'b101, 1);
        pwr_btn_n = 0; cyc(2); pwr_btn_n = 1; cyc(3);
        sw_write(3'b101, 1);
        batt_low = 1;
        pwr_btn_n = 0; cyc(2 * HOLD + 4); pwr_btn_n = 1;
        chk("R6", "override under battery low", rail_s5_n, 1'b0);
        cyc(3);
        batt_low = 0; cyc(3);
        tick_run = 0;
        cyc(4);
        summary();
    end
endmodule